// File: doc/BRIEF.md
# Load Data Extraction and Insert Unit

This block sits between the data returned by a memory read and the register file write port. It takes the raw read data together with the current contents of the destination register and produces the value to be written back. Byte and halfword loads are widened by sign or zero extension. Halfword and word loads can have their byte order reversed on the way in. A loaded byte or halfword can also be placed into one lane of the existing destination value while every other bit is kept.

A doubleword load produces two register values at once: one for the higher-numbered register of a pair and one for the lower. Memory is big-endian, so the word at the lower address goes to the higher register. The operation is presented with a valid strobe. The result appears on registered outputs one clock later and holds until the next valid operation. Address generation and bus handshaking happen elsewhere.

Top module: `ldx_unit`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `valid_o` and `pair_o` are 0 and `lo_o` and `hi_o` are all zeros.
- R2: `valid_o` equals `valid_i` delayed by one clock. When `valid_i` is 0, the outputs `lo_o`, `hi_o` and `pair_o` keep their previous values, whatever the other inputs do.
- R3: With `size_i`=00 (byte) and `ins_i`=0, `lo_o` is `rdata_i[7:0]` extended to 32 bits. The extension copies bit 7 when `sext_i`=1 and fills with zeros when `sext_i`=0. `swap_i` has no effect on byte loads.
- R4: With `size_i`=01 (halfword), `swap_i`=0 and `ins_i`=0, `lo_o` is `rdata_i[15:0]` extended from bit 15 when `sext_i`=1, or zero-filled when `sext_i`=0.
- R5: With `size_i`=01 and `swap_i`=1, the halfword is first taken as {`rdata_i[7:0]`, `rdata_i[15:8]`}. It is then extended (R4) or inserted (R8).
- R6: With `size_i`=10 (word), `lo_o` is `rdata_i[31:0]` when `swap_i`=0. When `swap_i`=1 the four bytes are fully reversed, so `lo_o[31:24]`=`rdata_i[7:0]` and `lo_o[7:0]`=`rdata_i[31:24]`. `sext_i`, `ins_i` and `lane_i` have no effect.
- R7: With `size_i`=00 and `ins_i`=1, bits [8L+7:8L] of `lo_o` take `rdata_i[7:0]`, where L=`lane_i` (0 to 3) and lane 0 is bits 7:0. The other three bytes equal `dest_i`.
- R8: With `size_i`=01 and `ins_i`=1, the halfword goes to bits 31:16 when `lane_i[0]`=1 and to bits 15:0 when `lane_i[0]`=0. The other half equals `dest_i`. `lane_i[1]` and `sext_i` have no effect.
- R9: With `size_i`=11 (doubleword), `hi_o`=`rdata_i[63:32]` (the lower-address word), `lo_o`=`rdata_i[31:0]` and `pair_o`=1. Swap, extend, insert and lane inputs have no effect. For every other size, `hi_o`=0 and `pair_o`=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation present this cycle |
| size_i | input | 2 | 00 byte, 01 halfword, 10 word, 11 doubleword |
| sext_i | input | 1 | 1 sign-extend, 0 zero-extend |
| swap_i | input | 1 | Reverse byte order of halfword or word |
| ins_i | input | 1 | Insert into lane instead of extending |
| lane_i | input | 2 | Byte lane, or halfword lane in bit 0 |
| rdata_i | input | 64 | Read data; bits 63:32 are the lower-address word |
| dest_i | input | 32 | Current destination register value |
| valid_o | output | 1 | Result registered this cycle |
| pair_o | output | 1 | Result is a register pair |
| lo_o | output | 32 | Destination value, or lower register of a pair |
| hi_o | output | 32 | Higher register of a pair, else zero |

## Verification
The hardest case to reach is the one where several mode inputs compete. Examples are a swapped halfword being inserted into the upper lane with the unused lane bit set, or a doubleword arriving with swap, insert and sign bits all high. A fault in the precedence between these inputs only shows in such combinations. The random stimulus draws every control bit independently of size, so these mixes come up often, and directed cases cover the sign boundary (bit 7 or 15 set) in each lane. Idle cycles with changed inputs are placed between operations, so that the output hold can be observed.

// File: rtl/ldx_pkg.sv
package ldx_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } ldx_size_e;
endpackage

// File: rtl/ldx_align.sv
// Byte, halfword and word forms of the low read word: swapping and extension.
module ldx_align #(
  parameter int W = 32
) (
  input  logic [W-1:0] rdata,
  input  logic         swap,
  input  logic         sext,
  output logic [W-1:0] byte_ext,
  output logic [15:0]  half_raw,
  output logic [W-1:0] half_ext,
  output logic [W-1:0] word_val
);
  localparam int NB = W / 8;

  logic [W-1:0] word_rev;

  for (genvar g = 0; g < NB; g++) begin : g_rev
    assign word_rev[8*g +: 8] = rdata[8*(NB-1-g) +: 8];
  end

  always_comb begin
    half_raw = swap ? {rdata[7:0], rdata[15:8]} : rdata[15:0];
    byte_ext = {{(W-8){sext & rdata[7]}}, rdata[7:0]};
    half_ext = {{(W-16){sext & half_raw[15]}}, half_raw};
    word_val = swap ? word_rev : rdata;
  end
endmodule

// File: rtl/ldx_merge.sv
// Places a byte or halfword into one lane of the old destination value.
module ldx_merge #(
  parameter int W      = 32,
  parameter int LANE_W = $clog2(W / 8)
) (
  input  logic [W-1:0]      dest,
  input  logic [7:0]        byte_in,
  input  logic [15:0]       half_in,
  input  logic              is_half,
  input  logic [LANE_W-1:0] lane,
  output logic [W-1:0]      merged
);
  localparam int NB   = W / 8;
  localparam int HL_W = (LANE_W > 1) ? LANE_W - 1 : 1;

  logic [HL_W-1:0] hlane;
  assign hlane = lane[HL_W-1:0];

  for (genvar g = 0; g < NB; g++) begin : g_lane
    localparam logic [LANE_W-1:0] BIDX = LANE_W'(g);
    localparam logic [HL_W-1:0]   HIDX = HL_W'(g / 2);
    always_comb begin
      merged[8*g +: 8] = dest[8*g +: 8];
      if (is_half) begin
        if (hlane == HIDX) merged[8*g +: 8] = half_in[8*(g%2) +: 8];
      end else begin
        if (lane == BIDX) merged[8*g +: 8] = byte_in;
      end
    end
  end
endmodule

// File: rtl/ldx_unit.sv
// Load result formatting with registered outputs.
module ldx_unit #(
  parameter int W      = 32,
  parameter int LANE_W = $clog2(W / 8)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid_i,
  input  logic [1:0]        size_i,
  input  logic              sext_i,
  input  logic              swap_i,
  input  logic              ins_i,
  input  logic [LANE_W-1:0] lane_i,
  input  logic [2*W-1:0]    rdata_i,
  input  logic [W-1:0]      dest_i,
  output logic              valid_o,
  output logic              pair_o,
  output logic [W-1:0]      lo_o,
  output logic [W-1:0]      hi_o
);
  import ldx_pkg::*;

  logic [W-1:0] byte_ext, half_ext, word_val, merged;
  logic [15:0]  half_raw;
  logic [W-1:0] nxt_lo, nxt_hi;
  logic         nxt_pair;
  ldx_size_e    sz;

  assign sz = ldx_size_e'(size_i);

  ldx_align #(.W(W)) u_align (
    .rdata    (rdata_i[W-1:0]),
    .swap     (swap_i),
    .sext     (sext_i),
    .byte_ext (byte_ext),
    .half_raw (half_raw),
    .half_ext (half_ext),
    .word_val (word_val)
  );

  ldx_merge #(.W(W), .LANE_W(LANE_W)) u_merge (
    .dest    (dest_i),
    .byte_in (rdata_i[7:0]),
    .half_in (half_raw),
    .is_half (sz == SZ_HALF),
    .lane    (lane_i),
    .merged  (merged)
  );

  always_comb begin
    nxt_lo   = '0;
    nxt_hi   = '0;
    nxt_pair = 1'b0;
    unique case (sz)
      SZ_BYTE:  nxt_lo = ins_i ? merged : byte_ext;
      SZ_HALF:  nxt_lo = ins_i ? merged : half_ext;
      SZ_WORD:  nxt_lo = word_val;
      SZ_DWORD: begin
        nxt_hi   = rdata_i[2*W-1:W];
        nxt_lo   = rdata_i[W-1:0];
        nxt_pair = 1'b1;
      end
      default: nxt_lo = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_o <= 1'b0;
      pair_o  <= 1'b0;
      lo_o    <= '0;
      hi_o    <= '0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        pair_o <= nxt_pair;
        lo_o   <= nxt_lo;
        hi_o   <= nxt_hi;
      end
    end
  end
endmodule

// File: rtl/ldx_unit_chk.sv
module ldx_unit_chk #(
  parameter int W      = 32,
  parameter int LANE_W = $clog2(W / 8)
) (
  input logic              clk,
  input logic              rst,
  input logic              valid_i,
  input logic [1:0]        size_i,
  input logic              sext_i,
  input logic              swap_i,
  input logic              ins_i,
  input logic [LANE_W-1:0] lane_i,
  input logic [2*W-1:0]    rdata_i,
  input logic [W-1:0]      dest_i,
  input logic              valid_o,
  input logic              pair_o,
  input logic [W-1:0]      lo_o,
  input logic [W-1:0]      hi_o
);
  logic [W-1:0] keep_mask;
  assign keep_mask = ~({{(W-8){1'b0}}, 8'hFF} << {lane_i, 3'b000});

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (!valid_o && !pair_o && lo_o == '0 && hi_o == '0));

  // R2
  a_r2_valid_delay: assert property (@(posedge clk) disable iff (rst)
    valid_i |=> valid_o);

  // R2
  a_r2_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !valid_i |=> (!valid_o && $stable(lo_o) && $stable(hi_o) && $stable(pair_o)));

  // R3
  a_r3_byte_sign_fill: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == 2'b00 && !ins_i && sext_i && rdata_i[7])
      |=> (lo_o[W-1:8] == '1));

  // R4
  a_r4_half_zero_fill: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == 2'b01 && !ins_i && !sext_i) |=> (lo_o[W-1:16] == '0));

  // R7
  a_r7_byte_keep_rest: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == 2'b00 && ins_i)
      |=> ((lo_o & $past(keep_mask)) == ($past(dest_i) & $past(keep_mask))));

  // R9
  a_r9_pair_words: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i == 2'b11)
      |=> (pair_o && hi_o == $past(rdata_i[2*W-1:W]) && lo_o == $past(rdata_i[W-1:0])));

  // R9
  a_r9_no_pair: assert property (@(posedge clk) disable iff (rst)
    (valid_i && size_i != 2'b11) |=> (!pair_o && hi_o == '0));
endmodule

bind ldx_unit ldx_unit_chk #(.W(W), .LANE_W(LANE_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .valid_i (valid_i),
  .size_i  (size_i),
  .sext_i  (sext_i),
  .swap_i  (swap_i),
  .ins_i   (ins_i),
  .lane_i  (lane_i),
  .rdata_i (rdata_i),
  .dest_i  (dest_i),
  .valid_o (valid_o),
  .pair_o  (pair_o),
  .lo_o    (lo_o),
  .hi_o    (hi_o)
);

// File: tb/ldx_unit_tb.sv
`timescale 1ns/1ps
module ldx_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        valid_i;
  logic [1:0]  size_i;
  logic        sext_i, swap_i, ins_i;
  logic [1:0]  lane_i;
  logic [63:0] rdata_i;
  logic [31:0] dest_i;
  logic        valid_o, pair_o;
  logic [31:0] lo_o, hi_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_lo, exp_hi;
  logic        exp_pair;

  always #4 clk = ~clk;

  ldx_unit u_dut (
    .clk(clk), .rst(rst), .valid_i(valid_i), .size_i(size_i),
    .sext_i(sext_i), .swap_i(swap_i), .ins_i(ins_i), .lane_i(lane_i),
    .rdata_i(rdata_i), .dest_i(dest_i), .valid_o(valid_o),
    .pair_o(pair_o), .lo_o(lo_o), .hi_o(hi_o)
  );

  function automatic string req_of(logic [1:0] sz, logic sw, logic ins);
    if (sz == 2'b11) return "R9";
    if (sz == 2'b10) return "R6";
    if (sz == 2'b00) return ins ? "R7" : "R3";
    if (ins) return "R8";
    return sw ? "R5" : "R4";
  endfunction

  // returns {pair, hi, lo}
  function automatic logic [64:0] model(logic [1:0] sz, logic sx, logic sw,
      logic ins, logic [1:0] ln, logic [63:0] rd, logic [31:0] ds);
    logic [31:0] r;
    logic [15:0] h;
    logic [7:0]  b;
    r = 32'h0;
    b = rd[7:0];
    h = sw ? {rd[7:0], rd[15:8]} : rd[15:0];
    case (sz)
      2'b00: begin
        if (ins) begin r = ds; r[8*ln +: 8] = b; end
        else r = sx ? {{24{b[7]}}, b} : {24'h0, b};
      end
      2'b01: begin
        if (ins) begin r = ds; r[16*ln[0] +: 16] = h; end
        else r = sx ? {{16{h[15]}}, h} : {16'h0, h};
      end
      2'b10: r = sw ? {rd[7:0], rd[15:8], rd[23:16], rd[31:24]} : rd[31:0];
      default: return {1'b1, rd[63:32], rd[31:0]};
    endcase
    return {1'b0, 32'h0, r};
  endfunction

  task automatic check(string req, logic [64:0] act, logic [64:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual pair=%0b hi=%08h lo=%08h expected pair=%0b hi=%08h lo=%08h",
               req, act[64], act[63:32], act[31:0], exp[64], exp[63:32], exp[31:0]);
    end
  endtask

  task automatic check_bit(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  // Called at a negedge: drive, then check at the next negedge.
  task automatic op(logic [1:0] sz, logic sx, logic sw, logic ins,
                    logic [1:0] ln, logic [63:0] rd, logic [31:0] ds);
    logic [64:0] e;
    valid_i = 1'b1; size_i = sz; sext_i = sx; swap_i = sw; ins_i = ins;
    lane_i = ln; rdata_i = rd; dest_i = ds;
    e = model(sz, sx, sw, ins, ln, rd, ds);
    {exp_pair, exp_hi, exp_lo} = e;
    @(negedge clk);
    check(req_of(sz, sw, ins), {pair_o, hi_o, lo_o}, e);
    check_bit("R2 valid", valid_o, 1'b1);
  endtask

  task automatic idle_check();
    valid_i = 1'b0;
    size_i = 2'($urandom); sext_i = 1'($urandom); swap_i = 1'($urandom);
    ins_i = 1'($urandom); lane_i = 2'($urandom);
    rdata_i = {$urandom, $urandom}; dest_i = $urandom;
    @(negedge clk);
    check("R2 hold", {pair_o, hi_o, lo_o}, {exp_pair, exp_hi, exp_lo});
    check_bit("R2 valid low", valid_o, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; valid_i = 1'b1; size_i = 2'b11; sext_i = 1'b0; swap_i = 1'b0;
    ins_i = 1'b0; lane_i = 2'b0; rdata_i = 64'hFFFF_FFFF_FFFF_FFFF; dest_i = '1;
    repeat (3) @(negedge clk);
    // R1: reset clears everything even with valid input present
    check("R1", {pair_o, hi_o, lo_o}, 65'h0);
    check_bit("R1 valid", valid_o, 1'b0);
    rst = 1'b0; valid_i = 1'b0;
    exp_pair = 1'b0; exp_hi = '0; exp_lo = '0;
    @(negedge clk);
    check("R1 after", {pair_o, hi_o, lo_o}, 65'h0);

    // R3 sign and zero extension, swap ignored
    op(2'b00, 1'b1, 1'b1, 1'b0, 2'd2, 64'h0000_0000_1234_5680, 32'hAAAA_AAAA);
    op(2'b00, 1'b0, 1'b0, 1'b0, 2'd0, 64'h0000_0000_1234_56FF, 32'h0);
    op(2'b00, 1'b1, 1'b0, 1'b0, 2'd0, 64'h0000_0000_FFFF_FF7F, 32'h0);
    // R4
    op(2'b01, 1'b1, 1'b0, 1'b0, 2'd0, 64'h0000_0000_0000_8001, 32'h0);
    op(2'b01, 1'b0, 1'b0, 1'b0, 2'd0, 64'h0000_0000_FFFF_8001, 32'h0);
    idle_check();
    // R5 swapped halfword: 0x0180 -> 0x8001
    op(2'b01, 1'b1, 1'b1, 1'b0, 2'd0, 64'h0000_0000_0000_0180, 32'h0);
    op(2'b01, 1'b0, 1'b1, 1'b0, 2'd0, 64'h0000_0000_0000_0180, 32'h0);
    // R6
    op(2'b10, 1'b1, 1'b1, 1'b1, 2'd3, 64'h0000_0000_1122_3344, 32'hFFFF_FFFF);
    op(2'b10, 1'b1, 1'b0, 1'b1, 2'd1, 64'h0000_0000_8899_AABB, 32'h0);
    // R7 each byte lane
    for (int l = 0; l < 4; l++)
      op(2'b00, 1'b1, 1'b0, 1'b1, 2'(l), 64'h0000_0000_0000_00C3, 32'h1122_3344);
    // R8 both halves, lane bit 1 set, swapped
    op(2'b01, 1'b1, 1'b1, 1'b1, 2'd3, 64'h0000_0000_0000_BEEF, 32'h1234_5678);
    op(2'b01, 1'b1, 1'b0, 1'b1, 2'd2, 64'h0000_0000_0000_BEEF, 32'h1234_5678);
    // R9
    op(2'b11, 1'b1, 1'b1, 1'b1, 2'd3, 64'hDEAD_BEEF_0BAD_F00D, 32'h5555_5555);
    idle_check();
    op(2'b10, 1'b0, 1'b0, 1'b0, 2'd0, 64'hFFFF_FFFF_0000_0001, 32'h0);

    for (int i = 0; i < 600; i++) begin
      op(2'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
         {$urandom, $urandom}, $urandom);
      if (($urandom % 5) == 0) idle_check();
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule